// File: doc/BRIEF.md
# External NMI Trigger and Pending Channel

This block conditions a single external non-maskable interrupt pin before it reaches an interrupt controller further down the chip. The raw pin is synchronised into the local clock domain. It is then examined according to a 2-bit trigger-type setting, which selects one of two levels or one of two edges. Any detected event sets a sticky pending flag. The flag stays set until software clears it.

Detection and storage are kept apart. Whatever polarity or edge is chosen at the pin, the signal sent downstream is simply the pending flag, ANDed with an enable bit, and presented as an active-high level. Software clears the flag through a write-one-to-clear strobe, which the surrounding register logic drives for one cycle per write of 1 to bit 0 of the pending register. A write of 0 produces no strobe.

Top module: `nmi_channel`

## Requirements
- R1: After a synchronous reset (`rst` high), `pending_o` and `irq_o` are both 0.
- R2: Trigger code 0 (`trig_type_i` = 2'b00) is level-low: while the synchronised pin is 0, the pending flag is set.
- R3: Trigger code 1 (2'b01) is falling-edge: a 1-to-0 transition of the synchronised pin sets the pending flag, and a pin held at 0 does not set it again after a clear.
- R4: Trigger code 2 (2'b10) is level-high: while the synchronised pin is 1, the pending flag is set.
- R5: Trigger code 3 (2'b11) is rising-edge: a 0-to-1 transition of the synchronised pin sets the pending flag, and a pin held at 1 does not set it again after a clear.
- R6: Once set, `pending_o` stays 1 in every trigger mode until a clear strobe arrives, even when the pin returns to its inactive value. Cycles with `pend_clr_i` at 0 leave it unchanged.
- R7: A cycle with `pend_clr_i` = 1 and no detected event makes `pending_o` 0 on the following cycle.
- R8: `irq_o` is an active-high level equal to `pending_o` when `irq_en_i` is 1, and is 0 when `irq_en_i` is 0. The enable does not alter `pending_o`.
- R9: In level modes, `pending_o` is 1 again on the cycle after a clear if the synchronised pin is still at its active level.
- R10: An event and a clear strobe in the same cycle leave `pending_o` at 1.
- R11: In the cycle in which `trig_type_i` changes, no edge event is reported, so the change of mode cannot create a false edge.
- R12: A pin change reaches `pending_o` after SYNC_STAGES + 1 clock edges: SYNC_STAGES edges for the synchroniser and one for the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin_i | input | 1 | Raw asynchronous NMI pin |
| trig_type_i | input | 2 | Trigger type: 0 level-low, 1 falling, 2 level-high, 3 rising |
| pend_clr_i | input | 1 | One-cycle clear strobe, driven when 1 is written to the pending bit |
| irq_en_i | input | 1 | Enable for the downstream output |
| pending_o | output | 1 | Sticky pending flag |
| irq_o | output | 1 | Gated active-high level to the downstream controller |

## Verification
The bench instantiates the block with SYNC_STAGES = 3 rather than the default of 2, so the latency check exercises the parameterised synchroniser depth and not a hard-wired value. PIN_RESET is left at 1, which keeps the level-low mode quiet just after reset. The bench sweeps the moment of a mode change across every cycle of a pin transition in flight, which is what reaches the history-reset corner. It also holds the clear strobe across an edge arrival, which is what reaches the set-wins collision.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_LO    = 2'd0,
        TRIG_EDGE_FALL = 2'd1,
        TRIG_LVL_HI    = 2'd2,
        TRIG_EDGE_RISE = 2'd3
    } trig_mode_e;

    // request into the pending latch
    typedef struct packed {
        logic set;
        logic clr;
    } latch_req_s;

    // odd codes are edges, even codes are levels
    function automatic logic mode_is_level(trig_mode_e m);
        return ~m[0];
    endfunction

    // upper bit selects the active pin value (high level / rising edge)
    function automatic logic mode_active_val(trig_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic PIN_RST = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic pin_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= PIN_RST;
        else     chain_q[0] <= pin_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= PIN_RST;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    assign pin_o = chain_q[LAST];

endmodule

// File: rtl/nmi_trigger_detect.sv
module nmi_trigger_detect
    import nmi_pkg::*;
#(
    parameter logic PIN_RST = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       samp_i,
    input  trig_mode_e mode_i,
    output logic       event_o
);
    logic       prev_q;
    trig_mode_e mode_q;
    logic       active_v;
    logic       level_hit;
    logic       edge_hit;
    logic       mode_stable;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= PIN_RST;
            mode_q <= TRIG_LVL_LO;
        end else begin
            prev_q <= samp_i;
            mode_q <= mode_i;
        end
    end

    always_comb begin
        active_v    = mode_active_val(mode_i);
        mode_stable = (mode_i == mode_q);
        level_hit   = (samp_i == active_v);
        edge_hit    = mode_stable && (prev_q != samp_i) && (samp_i == active_v);
        event_o     = mode_is_level(mode_i) ? level_hit : edge_hit;
    end

    // R11: a mode change never yields an edge event in that cycle
    p_no_false_edge_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (mode_i != $past(mode_i)) && !mode_is_level(mode_i)) |-> !event_o);

    // R5: rising sample under a steady rising mode is an event
    p_rise_detect_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_i == TRIG_EDGE_RISE && $past(mode_i) == TRIG_EDGE_RISE
         && $rose(samp_i)) |-> event_o);

    // R3: falling sample under a steady falling mode is an event
    p_fall_detect_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_i == TRIG_EDGE_FALL && $past(mode_i) == TRIG_EDGE_FALL
         && $fell(samp_i)) |-> event_o);

endmodule

// File: rtl/nmi_pend_latch.sv
module nmi_pend_latch
    import nmi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  latch_req_s req_i,
    output logic       pend_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)              pend_q <= 1'b0;
        else if (req_i.set)   pend_q <= 1'b1;
        else if (req_i.clr)   pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    // R10: set beats a simultaneous clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        req_i.set |=> pend_o);

    // R7: clear without set empties the latch
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (req_i.clr && !req_i.set) |=> !pend_o);

    // R6: held without a clear
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !req_i.clr) |=> pend_o);

    // R1: no spontaneous set
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
        (!pend_o && !req_i.set) |=> !pend_o);

endmodule

// File: rtl/nmi_channel.sv
module nmi_channel
    import nmi_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic PIN_RESET   = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       nmi_pin_i,
    input  logic [1:0] trig_type_i,
    input  logic       pend_clr_i,
    input  logic       irq_en_i,
    output logic       pending_o,
    output logic       irq_o
);
    trig_mode_e mode;
    logic       pin_s;
    logic       evt;
    latch_req_s req;

    assign mode = trig_mode_e'(trig_type_i);

    nmi_pin_sync #(.STAGES(SYNC_STAGES), .PIN_RST(PIN_RESET)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (nmi_pin_i),
        .pin_o (pin_s)
    );

    nmi_trigger_detect #(.PIN_RST(PIN_RESET)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .samp_i  (pin_s),
        .mode_i  (mode),
        .event_o (evt)
    );

    assign req.set = evt;
    assign req.clr = pend_clr_i;

    nmi_pend_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .pend_o (pending_o)
    );

    assign irq_o = pending_o & irq_en_i;

    // R4: high level in level-high mode is pending next cycle
    p_level_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_LVL_HI && pin_s) |=> pending_o);

    // R2 / R9: low level in level-low mode is pending next cycle, clear or not
    p_level_lo_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_LVL_LO && !pin_s) |=> pending_o);

endmodule

// File: tb/tb_nmi_channel.sv
module tb_nmi_channel;
    localparam int STAGES = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       pin;
    logic [1:0] trig;
    logic       clr;
    logic       en;
    logic       pending_o;
    logic       irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    logic       m_sync [STAGES];
    logic       m_prev;
    logic [1:0] m_mode;
    logic       m_pend;

    always #5 clk = ~clk;

    nmi_channel #(.SYNC_STAGES(STAGES), .PIN_RESET(1'b1)) dut (
        .clk         (clk),
        .rst         (rst),
        .nmi_pin_i   (pin),
        .trig_type_i (trig),
        .pend_clr_i  (clr),
        .irq_en_i    (en),
        .pending_o   (pending_o),
        .irq_o       (irq_o)
    );

    task automatic check(input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b t=%0t", what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < STAGES; i++) m_sync[i] = 1'b1;
        m_prev = 1'b1;
        m_mode = 2'd0;
        m_pend = 1'b0;
    endtask

    // drive inputs, advance the model by one edge, compare after it
    task automatic cyc(input logic p, input logic [1:0] t, input logic c,
                       input logic e, input string req);
        logic s, act_v, lvl, ev;
        pin = p; trig = t; clr = c; en = e;
        s     = m_sync[STAGES-1];
        act_v = t[1];
        lvl   = ~t[0];
        if (lvl) ev = (s == act_v);
        else     ev = (t == m_mode) && (m_prev != s) && (s == act_v);
        m_pend = ev | (m_pend & ~c);
        m_prev = s;
        m_mode = t;
        for (int i = STAGES-1; i > 0; i--) m_sync[i] = m_sync[i-1];
        m_sync[0] = p;
        @(negedge clk);
        check(pending_o, m_pend, {req, " pending"});
        check(irq_o, m_pend & e, {req, " irq"});
    endtask

    task automatic hold(input int n, input logic p, input logic [1:0] t,
                        input logic c, input logic e, input string req);
        for (int i = 0; i < n; i++) cyc(p, t, c, e, req);
    endtask

    initial begin
        int lat;
        int highs;
        rst = 1'b1; pin = 1'b1; trig = 2'd0; clr = 1'b0; en = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(pending_o, 1'b0, "R1 reset pending");
        check(irq_o, 1'b0, "R1 reset irq");

        // R2 level-low, R9 re-set after clear, R7 clear, R6 sticky
        hold(6, 1'b1, 2'd0, 1'b0, 1'b1, "R2");
        hold(6, 1'b0, 2'd0, 1'b0, 1'b1, "R2");
        check(pending_o, 1'b1, "R2 low level pends");
        cyc(1'b0, 2'd0, 1'b1, 1'b1, "R9");
        check(pending_o, 1'b1, "R9 level still active after clear");
        hold(6, 1'b1, 2'd0, 1'b0, 1'b1, "R6");
        check(pending_o, 1'b1, "R6 sticky after pin inactive");
        cyc(1'b1, 2'd0, 1'b1, 1'b1, "R7");
        check(pending_o, 1'b0, "R7 cleared");
        hold(4, 1'b1, 2'd0, 1'b0, 1'b1, "R7");

        // R3 falling edge
        hold(6, 1'b1, 2'd1, 1'b0, 1'b1, "R3");
        hold(6, 1'b0, 2'd1, 1'b0, 1'b1, "R3");
        check(pending_o, 1'b1, "R3 falling edge pends");
        cyc(1'b0, 2'd1, 1'b1, 1'b1, "R3");
        hold(5, 1'b0, 2'd1, 1'b0, 1'b1, "R3");
        check(pending_o, 1'b0, "R3 held low does not re-pend");

        // R4 level-high with R9
        hold(6, 1'b1, 2'd2, 1'b0, 1'b1, "R4");
        check(pending_o, 1'b1, "R4 high level pends");
        cyc(1'b1, 2'd2, 1'b1, 1'b1, "R9");
        check(pending_o, 1'b1, "R9 high level re-pends");
        hold(5, 1'b0, 2'd2, 1'b0, 1'b1, "R4");
        cyc(1'b0, 2'd2, 1'b1, 1'b1, "R4");
        check(pending_o, 1'b0, "R4 cleared while low");

        // R5 rising edge and R12 latency
        hold(6, 1'b0, 2'd3, 1'b0, 1'b1, "R5");
        lat = 0;
        for (int i = 0; i < 10; i++) begin
            cyc(1'b1, 2'd3, 1'b0, 1'b1, "R12");
            if (lat == 0 && pending_o) lat = i + 1;
        end
        total++;
        if (lat != STAGES + 1) begin
            bad++;
            $display("FAIL R12 latency: actual=%0d expected=%0d", lat, STAGES + 1);
        end
        cyc(1'b1, 2'd3, 1'b1, 1'b1, "R5");
        hold(5, 1'b1, 2'd3, 1'b0, 1'b1, "R5");
        check(pending_o, 1'b0, "R5 held high does not re-pend");

        // R8 enable gating
        hold(6, 1'b0, 2'd3, 1'b0, 1'b0, "R8");
        hold(6, 1'b1, 2'd3, 1'b0, 1'b0, "R8");
        check(pending_o, 1'b1, "R8 pending despite disable");
        check(irq_o, 1'b0, "R8 gated off");
        cyc(1'b1, 2'd3, 1'b0, 1'b1, "R8");
        check(irq_o, 1'b1, "R8 gated on");
        cyc(1'b1, 2'd3, 1'b1, 1'b1, "R8");

        // R10 clear held across an edge arrival: exactly one pending cycle
        hold(6, 1'b0, 2'd3, 1'b1, 1'b1, "R10");
        highs = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, 2'd3, 1'b1, 1'b1, "R10");
            if (pending_o) highs++;
        end
        total++;
        if (highs != 1) begin
            bad++;
            $display("FAIL R10 set-wins pulses: actual=%0d expected=1", highs);
        end

        // R11 mode change swept across a transition in flight
        for (int j = 0; j <= STAGES + 1; j++) begin
            hold(6, 1'b0, 2'd1, 1'b0, 1'b1, "R11");
            cyc(1'b0, 2'd1, 1'b1, 1'b1, "R11");
            for (int k = 0; k < STAGES + 3; k++)
                cyc(1'b1, (k >= j) ? 2'd3 : 2'd1, 1'b0, 1'b1, "R11");
            cyc(1'b1, 2'd3, 1'b1, 1'b1, "R11");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule